// File: doc/BRIEF.md
# Memory ECC Scrubber with Refresh-Rate Upgrade

This block walks every word of a memory on command. It reads each 72-bit stored word, which holds 64 data bits and 8 check bits, and tests it with a single-error-correcting, double-error-detecting code. A clean word is left alone. When a word has one bad bit, the block writes the repaired word back to the same address, with fresh check bits. It also emits a one-cycle upgrade pulse that carries the row holding that word, so that the refresh-rate table can move that row to the normal refresh rate for good. A word with two bad bits is left untouched and is reported on a fault output together with its address.

A system timer pulses the start input at a fixed interval, in the order of a quarter of an hour, and each pulse begins a full pass over memory. The row number is the word address shifted right by a parameter, so each row holds a power-of-two number of words. A start pulse that arrives while a pass is still running is dropped, and a flag records the drop. Two counters hold, for the latest pass, the number of repaired words and the number of fatal words.

Top module: `scrub_engine`

## Requirements
- R1: While reset is held and just after it ends, no request, upgrade pulse or fault pulse is issued. Busy is low, the drop flag is low and both counters read zero.
- R2: Codeword format. Codeword bit i holds Hamming position i. The check bits sit at positions 1, 2, 4, 8, 16, 32 and 64. The data bits 0 to 63 fill the remaining positions from 3 to 71 in ascending order. Bit 0 makes the whole 72-bit word even parity.
- R3: A start pulse while idle begins one pass. The pass reads each address from 0 to 2^ADDR_W-1 exactly once, in ascending order, and then the block returns to idle.
- R4: A word that decodes clean causes no write, no upgrade pulse and no fault pulse.
- R5: A word with one flipped bit is written back, fully corrected, to the address just read, before the next read is issued. The flipped bit may be a data bit, a check bit or bit 0.
- R6: Each corrected word raises the upgrade output for exactly one cycle, with row = word address >> ROW_SHIFT.
- R7: A word with two flipped bits raises the fault output for one cycle with its address. It causes no write and no upgrade, and the stored word stays as it was.
- R8: Both counters clear when a pass starts. Each counts up by one for each corrected word or each fatal word, and each holds its value after the pass until the next start.
- R9: A start pulse during a pass is ignored and sets the drop flag. The next accepted start clears the flag.
- R10: A request keeps its valid, address and direction steady until ready is seen. Back-pressure changes only the timing, never the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scrub_start | input | 1 | Timer pulse that requests a pass |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Word address |
| mem_req_wdata | output | 72 | Repaired codeword for a write |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 72 | Read codeword |
| upg_valid | output | 1 | One-cycle row upgrade pulse |
| upg_row | output | ADDR_W-ROW_SHIFT | Row to move to the normal rate |
| ue_valid | output | 1 | One-cycle fatal-error pulse |
| ue_addr | output | ADDR_W | Address of the fatal word |
| scrub_busy | output | 1 | Pass in progress |
| start_missed | output | 1 | A start arrived during a pass |
| ce_count | output | CNT_W | Corrected words in the latest pass |
| ue_count | output | CNT_W | Fatal words in the latest pass |

## Verification
The properties assume that the memory returns exactly one read response for each accepted read, and that no response arrives unless a read is outstanding. The bench memory model keeps to this: it answers one cycle after it accepts a read and never answers a write. The properties also assume that scrub_start is a clean one-cycle pulse. The bench drives it that way, and it issues the second pulse of the drop test well inside a running pass. Each stored word carries no more than two flipped bits. Three or more could alias to a single-bit pattern, which no stimulus creates.

// File: rtl/scrub_pkg.sv
// Package scrub_pkg
// Shared types and the (72,64) SECDED code used by the scrubber.
// Assumes codeword bit i is Hamming position i and bit 0 is overall parity.
package scrub_pkg;

    localparam int DATA_W = 64;
    localparam int CW_W   = 72;
    localparam int SYN_W  = 7;

    typedef enum logic [1:0] {
        ECC_CLEAN = 2'd0,
        ECC_FIXED = 2'd1,
        ECC_FATAL = 2'd2
    } ecc_stat_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RD    = 3'd1,
        ST_WAIT  = 3'd2,
        ST_CHECK = 3'd3,
        ST_WR    = 3'd4,
        ST_NEXT  = 3'd5
    } scrub_state_e;

    typedef struct packed {
        ecc_stat_e         status;
        logic [DATA_W-1:0] data;
    } dec_res_t;

    // True when position v is a power of two, meaning it is a check-bit slot
    function automatic logic is_chk_pos(input int v);
        return ((v & (v - 1)) == 0);
    endfunction

    // Builds a codeword from 64 data bits
    function automatic logic [CW_W-1:0] secded_encode(input logic [DATA_W-1:0] d);
        logic [CW_W-1:0] cw;
        logic            par;
        int              k;
        cw = '0;
        k  = 0;
        for (int pos = 1; pos < CW_W; pos++) begin
            if (!is_chk_pos(pos)) begin
                cw[pos] = d[k];
                k = k + 1;
            end
        end
        for (int j = 0; j < SYN_W; j++) begin
            par = 1'b0;
            for (int pos = 1; pos < CW_W; pos++) begin
                if ((((pos >> j) & 1) == 1) && !is_chk_pos(pos)) begin
                    par = par ^ cw[pos];
                end
            end
            cw[1 << j] = par;
        end
        cw[0] = ^cw[CW_W-1:1];
        return cw;
    endfunction

    // Classifies a codeword and returns the corrected data
    function automatic dec_res_t secded_decode(input logic [CW_W-1:0] cw_in);
        dec_res_t         r;
        logic [CW_W-1:0]  cw;
        logic [SYN_W-1:0] syn;
        logic             ov;
        int               k;
        cw  = cw_in;
        syn = '0;
        for (int pos = 1; pos < CW_W; pos++) begin
            for (int j = 0; j < SYN_W; j++) begin
                if (((pos >> j) & 1) == 1) begin
                    syn[j] = syn[j] ^ cw[pos];
                end
            end
        end
        ov       = ^cw;
        r.status = ECC_CLEAN;
        if (ov) begin
            if (syn < 7'd72) begin
                cw[syn]  = ~cw[syn];
                r.status = ECC_FIXED;
            end else begin
                r.status = ECC_FATAL;
            end
        end else if (syn != '0) begin
            r.status = ECC_FATAL;
        end
        r.data = '0;
        k = 0;
        for (int pos = 1; pos < CW_W; pos++) begin
            if (!is_chk_pos(pos)) begin
                r.data[k] = cw[pos];
                k = k + 1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/secded_check.sv
// Module secded_check
// Combinational SECDED decoder: classifies a stored codeword as clean,
// fixable or fatal, and returns the corrected data bits.
// Assumes the input is held stable by the caller for the cycle it is used.
module secded_check
    import scrub_pkg::*;
(
    input  logic [CW_W-1:0]   cw,
    output ecc_stat_e         status,
    output logic [DATA_W-1:0] data
);

    dec_res_t res;

    // Runs the decode function on the registered word
    always_comb begin
        res    = secded_decode(cw);
        status = res.status;
        data   = res.data;
    end

endmodule

// File: rtl/scrub_errcnt.sv
// Module scrub_errcnt
// Per-pass event counter: cleared at pass start, saturates at all ones.
// Assumes clr and inc are never high in the same cycle.
module scrub_errcnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Clears on a new pass and counts events without wrapping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && (count != CNT_MAX)) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/scrub_ctrl.sv
// Module scrub_ctrl
// Pass sequencer: issues the read for each address in turn, captures the
// returned word, acts on the decode result (write-back and upgrade, or
// fault report), then steps to the next address.
// Assumes one read response per accepted read and none otherwise.
module scrub_ctrl
    import scrub_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int ROW_SHIFT = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    req_ready,
    input  logic                    rsp_valid,
    input  logic [CW_W-1:0]         rsp_data,
    input  ecc_stat_e               dec_status,
    input  logic [DATA_W-1:0]       dec_data,
    output logic                    req_valid,
    output logic                    req_we,
    output logic [ADDR_W-1:0]       req_addr,
    output logic [CW_W-1:0]         req_wdata,
    output logic [CW_W-1:0]         word_q,
    output logic                    upg_valid,
    output logic [ADDR_W-ROW_SHIFT-1:0] upg_row,
    output logic                    ue_valid,
    output logic [ADDR_W-1:0]       ue_addr,
    output logic                    busy,
    output logic                    missed,
    output logic                    pass_clr,
    output logic                    ce_hit,
    output logic                    ue_hit
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    scrub_state_e      state;
    logic [ADDR_W-1:0] addr_q;
    logic [CW_W-1:0]   wbuf_q;

    // Decodes the present state into handshake and event strobes
    always_comb begin
        req_valid = (state == ST_RD) || (state == ST_WR);
        req_we    = (state == ST_WR);
        busy      = (state != ST_IDLE);
        pass_clr  = (state == ST_IDLE) && start;
        ce_hit    = (state == ST_CHECK) && (dec_status == ECC_FIXED);
        ue_hit    = (state == ST_CHECK) && (dec_status == ECC_FATAL);
    end

    assign req_addr  = addr_q;
    assign req_wdata = wbuf_q;

    // Steps the pass through read, check, optional write and advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            addr_q <= '0;
            word_q <= '0;
            wbuf_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        addr_q <= '0;
                        state  <= ST_RD;
                    end
                end
                ST_RD: begin
                    if (req_ready) begin
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (rsp_valid) begin
                        word_q <= rsp_data;
                        state  <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (dec_status == ECC_FIXED) begin
                        wbuf_q <= secded_encode(dec_data);
                        state  <= ST_WR;
                    end else begin
                        state <= ST_NEXT;
                    end
                end
                ST_WR: begin
                    if (req_ready) begin
                        state <= ST_NEXT;
                    end
                end
                ST_NEXT: begin
                    if (addr_q == LAST_ADDR) begin
                        state <= ST_IDLE;
                    end else begin
                        addr_q <= addr_q + 1'b1;
                        state  <= ST_RD;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Registers the one-cycle upgrade and fault reports
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upg_valid <= 1'b0;
            upg_row   <= '0;
            ue_valid  <= 1'b0;
            ue_addr   <= '0;
        end else begin
            upg_valid <= ce_hit;
            ue_valid  <= ue_hit;
            if (ce_hit) begin
                upg_row <= addr_q[ADDR_W-1:ROW_SHIFT];
            end
            if (ue_hit) begin
                ue_addr <= addr_q;
            end
        end
    end

    // Records a start pulse dropped during a pass
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            missed <= 1'b0;
        end else if (pass_clr) begin
            missed <= 1'b0;
        end else if (busy && start) begin
            missed <= 1'b1;
        end
    end

endmodule

// File: rtl/scrub_engine.sv
// Module scrub_engine
// Top of the memory scrubber: sequencer, SECDED decoder and the two
// per-pass counters (index 0 = corrected, index 1 = fatal).
// Assumes ROW_SHIFT < ADDR_W and a memory that answers each read once.
module scrub_engine
    import scrub_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int ROW_SHIFT = 2,
    parameter int CNT_W     = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        scrub_start,
    output logic                        mem_req_valid,
    input  logic                        mem_req_ready,
    output logic                        mem_req_we,
    output logic [ADDR_W-1:0]           mem_req_addr,
    output logic [71:0]                 mem_req_wdata,
    input  logic                        mem_rsp_valid,
    input  logic [71:0]                 mem_rsp_rdata,
    output logic                        upg_valid,
    output logic [ADDR_W-ROW_SHIFT-1:0] upg_row,
    output logic                        ue_valid,
    output logic [ADDR_W-1:0]           ue_addr,
    output logic                        scrub_busy,
    output logic                        start_missed,
    output logic [CNT_W-1:0]            ce_count,
    output logic [CNT_W-1:0]            ue_count
);

    localparam int N_CNT = 2;

    logic [CW_W-1:0]   word_q;
    ecc_stat_e         dec_status;
    logic [DATA_W-1:0] dec_data;
    logic              pass_clr;
    logic              ce_hit;
    logic              ue_hit;
    logic [N_CNT-1:0]  hit_vec;
    logic [CNT_W-1:0]  cnt_arr [N_CNT];

    scrub_ctrl #(
        .ADDR_W    (ADDR_W),
        .ROW_SHIFT (ROW_SHIFT)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (scrub_start),
        .req_ready  (mem_req_ready),
        .rsp_valid  (mem_rsp_valid),
        .rsp_data   (mem_rsp_rdata),
        .dec_status (dec_status),
        .dec_data   (dec_data),
        .req_valid  (mem_req_valid),
        .req_we     (mem_req_we),
        .req_addr   (mem_req_addr),
        .req_wdata  (mem_req_wdata),
        .word_q     (word_q),
        .upg_valid  (upg_valid),
        .upg_row    (upg_row),
        .ue_valid   (ue_valid),
        .ue_addr    (ue_addr),
        .busy       (scrub_busy),
        .missed     (start_missed),
        .pass_clr   (pass_clr),
        .ce_hit     (ce_hit),
        .ue_hit     (ue_hit)
    );

    secded_check u_dec (
        .cw     (word_q),
        .status (dec_status),
        .data   (dec_data)
    );

    assign hit_vec = {ue_hit, ce_hit};

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        scrub_errcnt #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (pass_clr),
            .inc   (hit_vec[g]),
            .count (cnt_arr[g])
        );
    end

    assign ce_count = cnt_arr[0];
    assign ue_count = cnt_arr[1];

endmodule

// File: rtl/scrub_engine_chk.sv
// Module scrub_engine_chk
// Temporal checks on the scrubber's ports, bound into every scrub_engine.
module scrub_engine_chk #(
    parameter int ADDR_W    = 6,
    parameter int ROW_SHIFT = 2,
    parameter int CNT_W     = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        scrub_start,
    input logic                        mem_req_valid,
    input logic                        mem_req_ready,
    input logic                        mem_req_we,
    input logic [ADDR_W-1:0]           mem_req_addr,
    input logic                        upg_valid,
    input logic [ADDR_W-ROW_SHIFT-1:0] upg_row,
    input logic                        ue_valid,
    input logic                        scrub_busy,
    input logic                        start_missed,
    input logic [CNT_W-1:0]            ce_count,
    input logic [CNT_W-1:0]            ue_count
);

    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)));

    // R6
    upg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upg_valid |=> !upg_valid);

    // R6
    upg_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upg_valid |-> (upg_row == mem_req_addr[ADDR_W-1:ROW_SHIFT]));

    // R5
    wr_after_upg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_we && !$past(mem_req_valid && mem_req_we)) |-> upg_valid);

    // R7
    no_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(upg_valid && ue_valid));

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !scrub_busy |-> !mem_req_valid);

    // R8
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!scrub_busy && !scrub_start) |=> ($stable(ce_count) && $stable(ue_count)));

    // R8
    ce_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upg_valid && ($past(ce_count) != CMAX)) |-> (ce_count == $past(ce_count) + 1'b1));

    // R8
    ue_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ue_valid && ($past(ue_count) != CMAX)) |-> (ue_count == $past(ue_count) + 1'b1));

    // R9
    missed_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scrub_busy && scrub_start) |=> start_missed);

endmodule

bind scrub_engine scrub_engine_chk #(
    .ADDR_W    (ADDR_W),
    .ROW_SHIFT (ROW_SHIFT),
    .CNT_W     (CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .scrub_start   (scrub_start),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .upg_valid     (upg_valid),
    .upg_row       (upg_row),
    .ue_valid      (ue_valid),
    .scrub_busy    (scrub_busy),
    .start_missed  (start_missed),
    .ce_count      (ce_count),
    .ue_count      (ue_count)
);

// File: tb/scrub_engine_tb.sv
// Directed bench for scrub_engine with a behavioural memory model.
module scrub_engine_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW    = 6;
    localparam int RS    = 2;
    localparam int CW    = 8;
    localparam int NWORD = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scrub_start = 1'b0;
    logic          mem_req_valid;
    logic          mem_req_ready;
    logic          mem_req_we;
    logic [AW-1:0] mem_req_addr;
    logic [71:0]   mem_req_wdata;
    logic          mem_rsp_valid;
    logic [71:0]   mem_rsp_rdata;
    logic          upg_valid;
    logic [AW-RS-1:0] upg_row;
    logic          ue_valid;
    logic [AW-1:0] ue_addr;
    logic          scrub_busy;
    logic          start_missed;
    logic [CW-1:0] ce_count;
    logic [CW-1:0] ue_count;

    int n_chk  = 0;
    int n_fail = 0;

    // memory model and logs
    logic [71:0]   mem [NWORD];
    logic          pre_we = 1'b0;
    logic [AW-1:0] pre_addr = '0;
    logic [71:0]   pre_data = '0;
    logic          log_clr = 1'b0;
    logic          stall_mode = 1'b0;
    logic          stall_tog = 1'b0;
    int            rd_cnt, wr_cnt, order_err, upg_n, ue_n;
    logic [AW-1:0] rd_next, last_rd;
    logic [AW-RS-1:0] upg_log [8];
    logic [AW-1:0]    ue_log [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_req_ready = !stall_mode || stall_tog;

    scrub_engine #(.ADDR_W(AW), .ROW_SHIFT(RS), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .scrub_start(scrub_start),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata), .upg_valid(upg_valid), .upg_row(upg_row),
        .ue_valid(ue_valid), .ue_addr(ue_addr), .scrub_busy(scrub_busy),
        .start_missed(start_missed), .ce_count(ce_count), .ue_count(ue_count)
    );

    // memory, response path and event logging
    always @(posedge clk) begin
        stall_tog     <= ~stall_tog;
        mem_rsp_valid <= 1'b0;
        if (pre_we) mem[pre_addr] <= pre_data;
        if (log_clr) begin
            rd_cnt <= 0; wr_cnt <= 0; order_err <= 0; upg_n <= 0; ue_n <= 0;
            rd_next <= '0; last_rd <= '0;
        end else begin
            if (mem_req_valid && mem_req_ready) begin
                if (mem_req_we) begin
                    mem[mem_req_addr] <= mem_req_wdata;
                    wr_cnt <= wr_cnt + 1;
                    if (mem_req_addr != last_rd) order_err <= order_err + 1;
                end else begin
                    mem_rsp_rdata <= mem[mem_req_addr];
                    mem_rsp_valid <= 1'b1;
                    rd_cnt <= rd_cnt + 1;
                    if (mem_req_addr != rd_next) order_err <= order_err + 1;
                    rd_next <= mem_req_addr + 1'b1;
                    last_rd <= mem_req_addr;
                end
            end
            if (upg_valid) begin
                if (upg_n < 8) upg_log[upg_n] <= upg_row;
                upg_n <= upg_n + 1;
            end
            if (ue_valid) begin
                if (ue_n < 8) ue_log[ue_n] <= ue_addr;
                ue_n <= ue_n + 1;
            end
        end
    end

    // bench encoder: check bits are the XOR of the positions of set data bits
    function automatic logic [71:0] ref_enc(input logic [63:0] d);
        logic [71:0] c;
        logic [6:0]  acc;
        int          idx;
        c = '0; acc = '0; idx = 0;
        for (int pos = 1; pos < 72; pos++) begin
            if ($countones(pos) != 1) begin
                c[pos] = d[idx];
                if (d[idx]) acc = acc ^ pos[6:0];
                idx++;
            end
        end
        for (int j = 0; j < 7; j++) c[1 << j] = acc[j];
        c[0] = ^c[71:1];
        return c;
    endfunction

    function automatic logic [63:0] pat(input int i);
        return 64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h9E37_79B9_7F4A_7C15);
    endfunction

    task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load_clean();
        for (int i = 0; i < NWORD; i++) begin
            @(negedge clk);
            pre_we = 1'b1; pre_addr = AW'(i); pre_data = ref_enc(pat(i));
        end
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    task automatic flip(input int a, input int b);
        @(negedge clk);
        pre_we = 1'b1; pre_addr = AW'(a); pre_data = mem[a] ^ (72'd1 << b);
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    task automatic clear_logs();
        @(negedge clk); log_clr = 1'b1;
        @(negedge clk); log_clr = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); scrub_start = 1'b1;
        @(negedge clk); scrub_start = 1'b0;
    endtask

    task automatic wait_idle();
        while (scrub_busy) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic int clean_mismatch();
        int m;
        m = 0;
        for (int i = 0; i < NWORD; i++) if (mem[i] !== ref_enc(pat(i))) m++;
        return m;
    endfunction

    task automatic t_reset();
        check("R1 busy", 72'(scrub_busy), 72'd0);
        check("R1 req_valid", 72'(mem_req_valid), 72'd0);
        check("R1 pulses", 72'({upg_valid, ue_valid}), 72'd0);
        check("R1 missed", 72'(start_missed), 72'd0);
        check("R1 counts", 72'({ce_count, ue_count}), 72'd0);
    endtask

    task automatic t_clean();
        load_clean(); clear_logs();
        pulse_start();
        check("R3 busy after start", 72'(scrub_busy), 72'd1);
        wait_idle();
        check("R3 reads", 72'(rd_cnt), 72'(NWORD));
        check("R3 order", 72'(order_err), 72'd0);
        check("R4 writes", 72'(wr_cnt), 72'd0);
        check("R4 upgrades", 72'(upg_n), 72'd0);
        check("R4 faults", 72'(ue_n), 72'd0);
        check("R2 memory intact", 72'(clean_mismatch()), 72'd0);
    endtask

    task automatic t_single();
        load_clean();
        flip(5, 10); flip(13, 8); flip(14, 0); flip(63, 71);
        clear_logs(); pulse_start(); wait_idle();
        check("R5 writes", 72'(wr_cnt), 72'd4);
        check("R5 write order", 72'(order_err), 72'd0);
        check("R5 R2 repaired memory", 72'(clean_mismatch()), 72'd0);
        check("R6 upgrade count", 72'(upg_n), 72'd4);
        check("R6 row0", 72'(upg_log[0]), 72'd1);
        check("R6 row1", 72'(upg_log[1]), 72'd3);
        check("R6 row2", 72'(upg_log[2]), 72'd3);
        check("R6 row3", 72'(upg_log[3]), 72'd15);
        check("R8 ce_count", 72'(ce_count), 72'd4);
        check("R8 ue_count", 72'(ue_count), 72'd0);
    endtask

    task automatic t_double();
        logic [71:0] bad2;
        load_clean();
        flip(2, 3); flip(2, 5); flip(40, 0); flip(40, 70); flip(41, 33);
        bad2 = mem[2];
        clear_logs(); pulse_start(); wait_idle();
        check("R7 fault count", 72'(ue_n), 72'd2);
        check("R7 fault addr0", 72'(ue_log[0]), 72'd2);
        check("R7 fault addr1", 72'(ue_log[1]), 72'd40);
        check("R7 only the single is written", 72'(wr_cnt), 72'd1);
        check("R7 upgrade count", 72'(upg_n), 72'd1);
        check("R6 row of word 41", 72'(upg_log[0]), 72'd10);
        check("R7 word left as is", mem[2], bad2);
        check("R8 ce_count", 72'(ce_count), 72'd1);
        check("R8 ue_count", 72'(ue_count), 72'd2);
    endtask

    task automatic t_counts();
        load_clean();
        check("R8 counts held", 72'({ce_count, ue_count}), {56'd0, 8'd1, 8'd2});
        clear_logs(); pulse_start(); wait_idle();
        check("R8 counts cleared", 72'({ce_count, ue_count}), 72'd0);
    endtask

    task automatic t_missed();
        load_clean(); flip(20, 44);
        clear_logs(); pulse_start();
        repeat (30) @(negedge clk);
        pulse_start();
        check("R9 flag set", 72'(start_missed), 72'd1);
        wait_idle();
        check("R9 no restart", 72'(rd_cnt), 72'(NWORD));
        check("R9 one upgrade", 72'(upg_n), 72'd1);
        check("R9 flag held", 72'(start_missed), 72'd1);
        pulse_start();
        check("R9 flag cleared", 72'(start_missed), 72'd0);
        wait_idle();
    endtask

    task automatic t_stall();
        load_clean(); flip(7, 50); flip(60, 1); flip(60, 2);
        @(negedge clk); stall_mode = 1'b1;
        clear_logs(); pulse_start(); wait_idle();
        check("R10 reads", 72'(rd_cnt), 72'(NWORD));
        check("R10 order", 72'(order_err), 72'd0);
        check("R10 writes", 72'(wr_cnt), 72'd1);
        check("R10 upgrade row", 72'(upg_log[0]), 72'd1);
        check("R10 fault addr", 72'(ue_log[0]), 72'd60);
        check("R10 word 7 repaired", mem[7], ref_enc(pat(7)));
        @(negedge clk); stall_mode = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean();
        t_single();
        t_double();
        t_counts();
        t_missed();
        t_stall();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule